// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device side of a three-wire serial port: a frame-enable line, a serial clock that rests high, and one data line shared by both ends. The block runs on the system clock, which must be well above the serial clock rate. All three serial lines pass through two-flop synchronisers, and serial clock edges are found inside the system clock domain. Every frame begins with an eight-bit header: a direction flag, a three-bit device code and a four-bit register address. The block acts on a frame only when the device code matches its own.

There are three kinds of frame. A write carries one data byte for the register file. A register read returns one byte. A bank read returns two bytes from a two-entry FIFO bank. A finished write is handed to the register file over a valid/ready channel. The register file and the FIFO return read data on plain combinational inputs, indexed by the address and bank select that the block drives. A watchdog watches the serial clock. If the clock stays high too long, the block drops any half-finished frame. This lets a master keep the frame-enable line tied high.

Top module: `ser3_slave`

## Requirements
- R1: After reset, `sdat_oe_o`, `reg_wvalid_o` and `fifo_rd_o` are all low.
- R2: A bit starts on each falling serial clock edge and is taken on the next rising edge. Header bit 0 is the direction flag (1 = read). Bits 1 to 3 are the device code, most significant bit first. Bits 4 to 7 are the address, most significant bit first.
- R3: A write frame (flag 0) with device code 3'b110 raises `reg_wvalid_o` once its sixteenth bit has been taken. The write carries the header address on `reg_waddr_o` and bits 8 to 15 on `reg_wdata_o`, most significant bit first. No write is issued earlier in the frame.
- R4: A frame whose device code differs from 3'b110 issues no write, pops no FIFO bank and never asserts `sdat_oe_o`.
- R5: A read frame whose address bits [3:2] are not 2'b00 is a register read. From the falling edge that starts bit 8, the block drives `reg_rdata_i` for address `reg_raddr_o` onto `sdat_o`, most significant bit first, one bit per serial clock, with `sdat_oe_o` high.
- R6: A read frame whose address bits [3:2] are 2'b00 is a bank read. Address bit 1 picks the bank on `fifo_bank_o`. From bit 8 the block drives 16 bits of `fifo_rdata_i`, bit 15 first (bits [15:8] hold the older entry). `fifo_rd_o` pulses high for exactly one cycle per bank read.
- R7: If the frame enable falls before bit 15 of a write has been taken, no write is issued.
- R8: If the serial clock stays high for TIMEOUT system cycles, the port resets and drops the partial frame, even while the frame enable stays high. The next falling edge then starts bit 0. A pause shorter than TIMEOUT does not break the frame.
- R9: `sdat_oe_o` goes low one cycle after the synchronised frame enable is low, and one cycle after a watchdog reset.
- R10: While `reg_wvalid_o` is high and `reg_wready_i` is low, `reg_wvalid_o`, `reg_waddr_o` and `reg_wdata_o` hold their values. A write is accepted on a cycle where both are high, and valid then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_i | input | 1 | Frame enable, high during a frame |
| sclk_i | input | 1 | Serial clock, rests high |
| sdat_i | input | 1 | Serial data from the pad |
| sdat_o | output | 1 | Serial data toward the pad |
| sdat_oe_o | output | 1 | Output enable for the data pad |
| reg_raddr_o | output | 4 | Register read address (header address) |
| reg_rdata_i | input | DATA_W | Register read data for `reg_raddr_o` |
| reg_waddr_o | output | 4 | Register write address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_wvalid_o | output | 1 | Write valid |
| reg_wready_i | input | 1 | Write ready from the register file |
| fifo_bank_o | output | 1 | FIFO bank select |
| fifo_rdata_i | input | 2*DATA_W | Selected bank contents, older entry in the upper half |
| fifo_rd_o | output | 1 | One-cycle pop of the selected bank |

## Verification
Each serial-line change reaches the design's registered outputs three system cycles later: two synchroniser flops, then the edge-qualified register. The master half period is eight cycles. The bench therefore takes returned data bits just before it raises the serial clock, five cycles after the slave's launch point. Write handshakes are seen at the falling system edge before the accepting rising edge. Each frame is followed by a fixed wait of forty cycles before its write count and data are compared, which covers the three-cycle path plus random ready stalls. Watchdog cases hold the clock high for TIMEOUT plus a margin before the next frame, and separately for a pause well under TIMEOUT.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  localparam int HDR_BITS = 8;
  localparam int ADDR_W   = 4;

  typedef struct packed {
    logic              rd;
    logic [2:0]        id;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ser3_idle_timer.sv
module ser3_idle_timer #(
  parameter int LIMIT = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  output logic tmo_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  // one pulse when the clock has rested high for LIMIT cycles
  assign tmo_o = sclk_s && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!sclk_s)              cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ser3_frame.sv
module ser3_frame
  import ser3_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter logic [2:0] ID_CODE = 3'b110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_s,
  input  logic                  sclk_s,
  input  logic                  sdat_s,
  input  logic                  tmo,
  input  logic [DATA_W-1:0]     reg_rdata_i,
  input  logic [2*DATA_W-1:0]   fifo_rdata_i,
  input  logic                  wr_ready_i,
  output logic [ADDR_W-1:0]     reg_raddr_o,
  output logic [ADDR_W-1:0]     reg_waddr_o,
  output logic [DATA_W-1:0]     reg_wdata_o,
  output logic                  wr_valid_o,
  output logic                  sdat_o,
  output logic                  sdat_oe_o,
  output logic                  fifo_bank_o,
  output logic                  fifo_rd_o
);
  localparam int REG_BITS  = HDR_BITS + DATA_W;
  localparam int FIFO_BITS = HDR_BITS + 2 * DATA_W;
  localparam int CW        = $clog2(FIFO_BITS + 2);
  localparam int TX_W      = 2 * DATA_W;

  logic              sclk_q;
  logic              abort, fall, rise;
  logic [CW-1:0]     cnt_q;
  hdr_t              hdr_q;
  logic              hdr_done_q;
  logic [DATA_W-1:0] wsh_q;
  logic [TX_W-1:0]   tx_q;
  logic              oe_q;
  logic              wr_valid_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              fifo_rd_q;
  logic              hit, is_bank, last_wbit, tx_start;

  always_comb begin
    abort     = !en_s || tmo;
    fall      = sclk_q && !sclk_s && !abort;
    rise      = !sclk_q && sclk_s && !abort;
    hit       = hdr_done_q && (hdr_q.id == ID_CODE);
    is_bank   = (hdr_q.addr[ADDR_W-1:ADDR_W-2] == 2'b00);
    last_wbit = rise && (cnt_q == CW'(REG_BITS)) && hit && !hdr_q.rd;
    tx_start  = fall && (cnt_q == CW'(HDR_BITS)) && hit && hdr_q.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_s;
  end

  // bit counter and header / write-data capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      hdr_q      <= '0;
      hdr_done_q <= 1'b0;
      wsh_q      <= '0;
    end else if (abort) begin
      cnt_q      <= '0;
      hdr_q      <= '0;
      hdr_done_q <= 1'b0;
    end else begin
      if (fall && cnt_q != CW'(FIFO_BITS + 1)) cnt_q <= cnt_q + 1'b1;
      if (rise && cnt_q != '0 && cnt_q <= CW'(HDR_BITS))
        hdr_q <= hdr_t'({hdr_q[HDR_BITS-2:0], sdat_s});
      if (rise && cnt_q == CW'(HDR_BITS)) hdr_done_q <= 1'b1;
      if (rise && cnt_q > CW'(HDR_BITS) && cnt_q <= CW'(REG_BITS))
        wsh_q <= {wsh_q[DATA_W-2:0], sdat_s};
    end
  end

  // write channel toward the register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_q <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else if (last_wbit) begin
      wr_valid_q <= 1'b1;
      waddr_q    <= hdr_q.addr;
      wdata_q    <= {wsh_q[DATA_W-2:0], sdat_s};
    end else if (wr_ready_i) begin
      wr_valid_q <= 1'b0;
    end
  end

  // read-data launch on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '0;
      oe_q      <= 1'b0;
      fifo_rd_q <= 1'b0;
    end else begin
      fifo_rd_q <= 1'b0;
      if (abort) begin
        oe_q <= 1'b0;
      end else if (tx_start) begin
        oe_q      <= 1'b1;
        tx_q      <= is_bank ? fifo_rdata_i : {reg_rdata_i, {DATA_W{1'b0}}};
        fifo_rd_q <= is_bank;
      end else if (fall && oe_q) begin
        tx_q <= {tx_q[TX_W-2:0], 1'b0};
      end
    end
  end

  assign reg_raddr_o = hdr_q.addr;
  assign reg_waddr_o = waddr_q;
  assign reg_wdata_o = wdata_q;
  assign wr_valid_o  = wr_valid_q;
  assign sdat_o      = tx_q[TX_W-1];
  assign sdat_oe_o   = oe_q;
  assign fifo_bank_o = hdr_q.addr[1];
  assign fifo_rd_o   = fifo_rd_q;
endmodule

// File: rtl/ser3_slave.sv
module ser3_slave
  import ser3_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         TIMEOUT = 280,
  parameter logic [2:0] ID_CODE = 3'b110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sen_i,
  input  logic                sclk_i,
  input  logic                sdat_i,
  output logic                sdat_o,
  output logic                sdat_oe_o,
  output logic [ADDR_W-1:0]   reg_raddr_o,
  input  logic [DATA_W-1:0]   reg_rdata_i,
  output logic [ADDR_W-1:0]   reg_waddr_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  output logic                reg_wvalid_o,
  input  logic                reg_wready_i,
  output logic                fifo_bank_o,
  input  logic [2*DATA_W-1:0] fifo_rdata_i,
  output logic                fifo_rd_o
);
  logic en_s, sclk_s, sdat_s, tmo;

  // enable rests low, clock rests high
  ser3_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sen_i, sclk_i, sdat_i}),
    .q_o({en_s, sclk_s, sdat_s})
  );

  ser3_idle_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .tmo_o(tmo)
  );

  ser3_frame #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .en_s(en_s), .sclk_s(sclk_s), .sdat_s(sdat_s), .tmo(tmo),
    .reg_rdata_i(reg_rdata_i), .fifo_rdata_i(fifo_rdata_i),
    .wr_ready_i(reg_wready_i),
    .reg_raddr_o(reg_raddr_o), .reg_waddr_o(reg_waddr_o),
    .reg_wdata_o(reg_wdata_o), .wr_valid_o(reg_wvalid_o),
    .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o),
    .fifo_bank_o(fifo_bank_o), .fifo_rd_o(fifo_rd_o)
  );
endmodule

// File: rtl/ser3_slave_chk.sv
module ser3_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic              tmo,
  input logic              sdat_oe_o,
  input logic              reg_wvalid_o,
  input logic              reg_wready_i,
  input logic [3:0]        reg_waddr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              fifo_rd_o
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wvalid_o && !reg_wready_i) |=>
      (reg_wvalid_o && $stable(reg_waddr_o) && $stable(reg_wdata_o)));

  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wvalid_o && reg_wready_i) |=> !reg_wvalid_o);

  a_r9_oe_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !sdat_oe_o);

  a_r9_oe_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !sdat_oe_o);

  a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |=> !fifo_rd_o);
endmodule

bind ser3_slave ser3_slave_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .tmo(tmo),
  .sdat_oe_o(sdat_oe_o), .reg_wvalid_o(reg_wvalid_o),
  .reg_wready_i(reg_wready_i), .reg_waddr_o(reg_waddr_o),
  .reg_wdata_o(reg_wdata_o), .fifo_rd_o(fifo_rd_o)
);

// File: tb/test_ser3_slave.sv
module test_ser3_slave;
  localparam int H   = 8;
  localparam int TMO = 280;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sen = 1'b0, sclk = 1'b1, sdat = 1'b0;
  logic        sdat_o, sdat_oe;
  logic [3:0]  raddr, waddr;
  logic [7:0]  rdata, wdata;
  logic        wvalid, wready = 1'b1;
  logic        bank, fifo_rd;
  logic [15:0] fdata;

  int checks = 0, errors = 0;
  int n_wr = 0, n_pop = 0;
  logic [3:0] last_a;
  logic [7:0] last_d;
  logic       last_bank;
  bit         rdy_force = 1'b1, rdy_val = 1'b1;

  localparam logic [15:0] BANK0 = 16'hA17C;
  localparam logic [15:0] BANK1 = 16'h3E94;

  function automatic logic [7:0] exp_reg(input logic [3:0] a);
    return 8'(({4'b0, a} * 8'd29) ^ 8'h5A);
  endfunction

  function automatic logic [23:0] mk(input logic rd, input logic [2:0] id,
                                     input logic [3:0] a, input logic [15:0] d);
    return {rd, id, a, d};
  endfunction

  assign rdata = exp_reg(raddr);
  assign fdata = bank ? BANK1 : BANK0;

  ser3_slave i_ser3_slave (
    .clk(clk), .rst_n(rst_n), .sen_i(sen), .sclk_i(sclk), .sdat_i(sdat),
    .sdat_o(sdat_o), .sdat_oe_o(sdat_oe),
    .reg_raddr_o(raddr), .reg_rdata_i(rdata),
    .reg_waddr_o(waddr), .reg_wdata_o(wdata),
    .reg_wvalid_o(wvalid), .reg_wready_i(wready),
    .fifo_bank_o(bank), .fifo_rdata_i(fdata), .fifo_rd_o(fifo_rd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // handshake monitor, sampled at the falling system edge
  always @(negedge clk) begin
    if (rst_n && wvalid && wready) begin
      n_wr++; last_a = waddr; last_d = wdata;
    end
    if (rst_n && fifo_rd) begin
      n_pop++; last_bank = bank;
    end
  end

  initial forever begin
    @(posedge clk); #2;
    wready = rdy_force ? rdy_val : ($urandom % 4 != 0);
  end

  logic [15:0] got;
  int          oe_hi, oe_any;

  // n bits of frame f, MSB first; keep=1 leaves the enable line untouched
  task automatic frame(input logic [23:0] f, input int n, input bit keep);
    got = '0; oe_hi = 0; oe_any = 0;
    if (!keep) begin
      @(negedge clk); sen = 1'b1;
      repeat (H) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b0; sdat = f[23-i];
      repeat (H) @(negedge clk);
      if (sdat_oe) oe_any++;
      if (i >= 8) begin
        got = {got[14:0], sdat_o};
        if (sdat_oe) oe_hi++;
      end
      sclk = 1'b1;
      repeat (H - 1) @(negedge clk);
    end
    repeat (H) @(negedge clk);
    if (!keep) sen = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int w0, p0;
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!sdat_oe, "R1", "oe after reset", sdat_oe, 0);
    chk(!wvalid, "R1", "wvalid after reset", wvalid, 0);
    chk(!fifo_rd, "R1", "fifo_rd after reset", fifo_rd, 0);

    // R2/R3 basic write
    w0 = n_wr;
    frame(mk(1'b0, 3'b110, 4'h5, 16'hC300), 16, 0);
    chk(n_wr == w0 + 1, "R3", "write count", n_wr - w0, 1);
    chk(last_a == 4'h5, "R2", "write address", last_a, 5);
    chk(last_d == 8'hC3, "R3", "write data", last_d, 8'hC3);

    // R7 write cut short by enable fall after 15 bits
    w0 = n_wr;
    frame(mk(1'b0, 3'b110, 4'h6, 16'h1100), 15, 0);
    chk(n_wr == w0, "R7", "aborted write count", n_wr - w0, 0);

    // R4 wrong device codes
    w0 = n_wr; p0 = n_pop;
    frame(mk(1'b0, 3'b101, 4'h7, 16'h4400), 16, 0);
    chk(n_wr == w0, "R4", "bad-id write", n_wr - w0, 0);
    frame(mk(1'b1, 3'b010, 4'h9, 16'h0), 16, 0);
    chk(oe_any == 0, "R4", "bad-id read oe", oe_any, 0);
    frame(mk(1'b1, 3'b111, 4'h0, 16'h0), 24, 0);
    chk(n_pop == p0 && oe_any == 0, "R4", "bad-id bank read", n_pop - p0, 0);

    // R5 register read
    frame(mk(1'b1, 3'b110, 4'h9, 16'h0), 16, 0);
    chk(got[7:0] == exp_reg(4'h9), "R5", "reg read data", got[7:0], exp_reg(4'h9));
    chk(oe_hi == 8, "R5", "oe during data bits", oe_hi, 8);
    // R9 released after enable fall
    chk(!sdat_oe, "R9", "oe after frame end", sdat_oe, 0);

    // R6 bank reads
    p0 = n_pop;
    frame(mk(1'b1, 3'b110, 4'h0, 16'h0), 24, 0);
    chk(got == BANK0, "R6", "bank0 data", got, BANK0);
    chk(n_pop == p0 + 1 && last_bank == 1'b0, "R6", "bank0 pop", n_pop - p0, 1);
    frame(mk(1'b1, 3'b110, 4'h3, 16'h0), 24, 0);
    chk(got == BANK1, "R6", "bank1 data", got, BANK1);
    chk(n_pop == p0 + 2 && last_bank == 1'b1, "R6", "bank1 pop", n_pop - p0, 2);

    // R8 enable tied high: garbage, timeout, then clean write
    @(negedge clk); sen = 1'b1;
    repeat (TMO + 20) @(negedge clk);
    w0 = n_wr;
    frame(mk(1'b0, 3'b110, 4'hE, 16'h0), 6, 1);
    repeat (TMO + 20) @(negedge clk);
    frame(mk(1'b0, 3'b110, 4'hA, 16'h5D00), 16, 1);
    chk(n_wr == w0 + 1 && last_a == 4'hA && last_d == 8'h5D, "R8",
        "write after timeout", {last_a, last_d}, 16'hA5D);
    repeat (TMO + 20) @(negedge clk);
    // R8 short pause mid-frame keeps the frame
    w0 = n_wr;
    frame(mk(1'b0, 3'b110, 4'hB, 16'h0), 10, 1);
    repeat (TMO / 3) @(negedge clk);
    frame({6'b011110, 18'h0}, 6, 1);
    chk(n_wr == w0 + 1 && last_d == 8'h1E, "R8", "short pause write", last_d, 8'h1E);
    repeat (TMO + 20) @(negedge clk);
    // R9 oe drops on timeout while enable still high
    frame(mk(1'b1, 3'b110, 4'h4, 16'h0), 11, 1);
    chk(sdat_oe == 1'b1, "R9", "oe mid read", sdat_oe, 1);
    repeat (TMO + 5) @(negedge clk);
    chk(!sdat_oe, "R9", "oe after timeout", sdat_oe, 0);
    sen = 1'b0;
    repeat (10) @(negedge clk);

    // R10 back-pressure
    rdy_val = 1'b0;
    w0 = n_wr;
    frame(mk(1'b0, 3'b110, 4'h2, 16'h9600), 16, 0);
    chk(wvalid && waddr == 4'h2 && wdata == 8'h96, "R10", "held write",
        {wvalid, waddr, wdata}, 13'h1296);
    repeat (30) @(negedge clk);
    chk(wvalid && wdata == 8'h96 && n_wr == w0, "R10", "still held", wdata, 8'h96);
    rdy_val = 1'b1;
    repeat (3) @(negedge clk);
    chk(n_wr == w0 + 1 && !wvalid, "R10", "accepted once", n_wr - w0, 1);

    // random mix, random ready
    void'($urandom(32'h5EED));
    rdy_force = 1'b0;
    for (int k = 0; k < 40; k++) begin
      logic [2:0] id; logic [3:0] a; logic [7:0] d; int kind;
      id   = ($urandom % 4 == 0) ? 3'($urandom) : 3'b110;
      a    = 4'($urandom);
      d    = 8'($urandom);
      kind = $urandom % 2;
      w0 = n_wr; p0 = n_pop;
      if (kind == 0) begin
        frame(mk(1'b0, id, a, {d, 8'h0}), 16, 0);
        if (id == 3'b110)
          chk(n_wr == w0 + 1 && last_a == a && last_d == d, "R3", "random write",
              {last_a, last_d}, {a, d});
        else
          chk(n_wr == w0, "R4", "random bad-id write", n_wr - w0, 0);
      end else if (a[3:2] != 2'b00) begin
        frame(mk(1'b1, id, a, 16'h0), 16, 0);
        if (id == 3'b110)
          chk(got[7:0] == exp_reg(a), "R5", "random reg read", got[7:0], exp_reg(a));
        else
          chk(oe_any == 0, "R4", "random bad-id read", oe_any, 0);
      end else begin
        frame(mk(1'b1, id, a, 16'h0), 24, 0);
        if (id == 3'b110)
          chk(got == (a[1] ? BANK1 : BANK0) && n_pop == p0 + 1, "R6",
              "random bank read", got, a[1] ? BANK1 : BANK0);
        else
          chk(n_pop == p0 && oe_any == 0, "R4", "random bad-id bank", n_pop - p0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule